// File: doc/BRIEF.md
# Split-Word Mailbox Queue

This block is a first-in first-out message queue. A producer pushes 64-bit messages with a one-cycle valid strobe. A processor reads each message through a 32-bit configuration read port as two words at two register offsets. A read of the low-word offset returns the lower half of the oldest message and leaves the queue as it is. A read of the high-word offset returns the upper half and removes that message. Software therefore reads low first and high second.

The queue drives a not-empty flag, which is meant to feed an interrupt line, and a full flag. Pushes that arrive while the queue is full are discarded. Both sides run on one clock. The depth is a power-of-two parameter. The storage is a simple dual-port array with a synchronous read, so it can map onto block RAM.

Top module: `mbox_queue`

## Requirements
- R1: After reset, `not_empty` and `full` are 0 and `cfg_rdata` is 0.
- R2: A read (`cfg_rd`=1) at offset `LO_OFS` (default 0x0) on a non-empty queue returns bits 31:0 of the oldest entry on `cfg_rdata` in the cycle after the read, and removes nothing. Repeated low reads return the same word.
- R3: A read at offset `HI_OFS` (default 0x4) on a non-empty queue returns bits 63:32 of the oldest entry in the cycle after the read, and removes exactly that one entry.
- R4: Entries leave in the order in which they were accepted, including across pointer wrap-around.
- R5: `not_empty` is 1 exactly when at least one entry is held.
- R6: `full` is 1 exactly when `DEPTH` entries are held.
- R7: A push while `full` is 1 is dropped, and the held entries stay unchanged, even when a high-word read happens in the same cycle.
- R8: A low or high read while the queue is empty returns 0 and changes nothing.
- R9: A push and a high-word read in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged.
- R10: In a cycle after one with no read, or with a read at any other offset, `cfg_rdata` is 0. Such a read removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push strobe for one message |
| push_data | input | DATA_W (64) | Message to enqueue |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W (8) | Configuration read offset |
| cfg_rdata | output | DATA_W/2 (32) | Read data, valid the cycle after `cfg_rd` |
| not_empty | output | 1 | At least one message held (interrupt request) |
| full | output | 1 | No further message can be accepted |

## Verification
The bench runs the queue at depth 4, so wrap-around and the full boundary are reached often. It sweeps arithmetic mixes of pushes and reads at the low, high and unrelated offsets against a queue model. Specific cases target bugs that would otherwise go unnoticed. A design that pops on low reads fails the repeated-low check. One that accepts a push while full overwrites the head and breaks the drained order. One that moves the read pointer on an empty high read later returns stale data. One that mishandles a simultaneous push and pop shows a wrong flag or a lost message.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LO   = 2'd1,
    RD_HI   = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/mbox_ptrs.sv
module mbox_ptrs #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             is_empty,
  output logic             is_full
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [PTR_W-1:0] occ;

  assign occ      = wr_ptr_q - rd_ptr_q;
  assign is_empty = (wr_ptr_q == rd_ptr_q);
  assign is_full  = (wr_ptr_q[IDX_W-1:0] == rd_ptr_q[IDX_W-1:0]) &&
                    (wr_ptr_q[IDX_W] != rd_ptr_q[IDX_W]);
  assign push_ok  = push_req && !is_full;
  assign pop_ok   = pop_req && !is_empty;
  assign wr_idx   = wr_ptr_q[IDX_W-1:0];
  assign rd_idx   = rd_ptr_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  // R7: a push into a full queue leaves the write pointer alone
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (push_req && is_full) |=> $stable(wr_ptr_q));
  // R8: a pop request on an empty queue leaves the read pointer alone
  p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pop_req && is_empty) |=> $stable(rd_ptr_q));
  // R3: a granted pop advances the read pointer by one
  p_pop_step_r3: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !is_empty) |=> (rd_ptr_q == $past(rd_ptr_q) + 1'b1));
  // R9: a push and a pop together keep the occupancy
  p_occ_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !is_empty && !is_full) |=> $stable(occ));
  // R6: occupancy never exceeds the depth
  p_occ_bound_r6: assert property (@(posedge clk) disable iff (rst)
    occ <= PTR_W'(DEPTH));
endmodule

// File: rtl/mbox_queue.sv
module mbox_queue
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h0,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h4,
  localparam int HALF_W = DATA_W / 2,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [HALF_W-1:0] cfg_rdata,
  output logic              not_empty,
  output logic              full
);
  rd_kind_e          kind;
  logic              push_ok, pop_ok, is_empty, is_full;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] ram_q;
  logic              sel_hi_q, zero_q;

  always_comb begin
    kind = RD_NONE;
    if (cfg_rd && cfg_addr == LO_OFS) kind = RD_LO;
    else if (cfg_rd && cfg_addr == HI_OFS) kind = RD_HI;
  end

  mbox_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_valid),
    .pop_req  (kind == RD_HI),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .is_empty (is_empty),
    .is_full  (is_full)
  );

  mbox_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .we      (push_ok),
    .waddr   (wr_idx),
    .wdata   (push_data),
    .raddr   (rd_idx),
    .rdata_q (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hi_q <= 1'b0;
      zero_q   <= 1'b1;
    end else begin
      sel_hi_q <= (kind == RD_HI);
      zero_q   <= (kind == RD_NONE) || is_empty;
    end
  end

  assign cfg_rdata = zero_q ? '0 : (sel_hi_q ? ram_q[DATA_W-1:HALF_W] : ram_q[HALF_W-1:0]);
  assign not_empty = !is_empty;
  assign full      = is_full;

  // R8: a read on an empty queue returns zero
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && is_empty) |=> (cfg_rdata == '0));
  // R10: no read, or a read at an unrelated offset, returns zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (kind == RD_NONE) |=> (cfg_rdata == '0));
  // R2: a low read leaves the not-empty flag set
  p_lo_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (kind == RD_LO && !is_empty && !push_valid) |=> not_empty);
  // R6: full implies not empty
  p_full_ne_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> not_empty);
  // R5: not_empty becomes 1 one cycle after a push into an empty queue
  p_ne_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (push_valid && is_empty) |=> not_empty);
endmodule

// File: tb/mbox_queue_tb.sv
module mbox_queue_tb;
  localparam int D  = 4;
  localparam logic [7:0] LO = 8'h00;
  localparam logic [7:0] HI = 8'h04;

  logic        clk = 1'b0;
  logic        rst;
  logic        push_valid;
  logic [63:0] push_data;
  logic        cfg_rd;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_rdata;
  logic        not_empty, full;

  int checks = 0;
  int errors = 0;
  logic [63:0] mq [D];
  int head = 0;
  int cnt  = 0;

  always #5 clk = ~clk;

  mbox_queue #(.DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
    .not_empty(not_empty), .full(full)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int k);
    logic [31:0] a = 32'h9E37_79B9 * 32'(k + 1);
    return {a ^ 32'h5A5A_0000, ~a + 32'(k)};
  endfunction

  // One cycle: drive at negedge, let the edge pass, check at the next negedge.
  task automatic step(input bit dp, input logic [63:0] dd, input bit dr,
                      input logic [7:0] da, input string tag);
    logic [31:0] exp_rd;
    bit pop, pok;
    exp_rd = '0;
    pop = dr && da == HI && cnt > 0;
    pok = dp && cnt < D;
    if (dr && cnt > 0 && da == LO) exp_rd = mq[head][31:0];
    if (pop) exp_rd = mq[head][63:32];
    push_valid = dp; push_data = dd; cfg_rd = dr; cfg_addr = da;
    @(negedge clk);
    push_valid = 1'b0; cfg_rd = 1'b0;
    if (pok) mq[(head + cnt) % D] = dd;
    if (pop) begin head = (head + 1) % D; cnt--; end
    if (pok) cnt++;
    check(cfg_rdata == exp_rd, tag, 64'(cfg_rdata), 64'(exp_rd));
    check(not_empty == (cnt > 0), "R5 not_empty", 64'(not_empty), 64'(cnt > 0));
    check(full == (cnt == D), "R6 full", 64'(full), 64'(cnt == D));
  endtask

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; push_valid = 1'b0; push_data = '0; cfg_rd = 1'b0; cfg_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(not_empty == 1'b0, "R1 not_empty", 64'(not_empty), 64'd0);
    check(full == 1'b0, "R1 full", 64'(full), 64'd0);
    check(cfg_rdata == '0, "R1 rdata", 64'(cfg_rdata), 64'd0);
    // R8: reads while empty
    step(0, '0, 1, LO, "R8 empty low");
    step(0, '0, 1, HI, "R8 empty high");
    step(0, '0, 1, HI, "R8 empty high again");
    // fill, then R7 dropped push while full
    for (int k = 0; k < D; k++) step(1, pat(k), 0, LO, "R10 idle");
    step(1, pat(99), 0, LO, "R7 push while full");
    step(1, pat(98), 1, HI, "R7 push and pop while full");
    // R2: repeated low reads, R10 unrelated offset
    step(0, '0, 1, LO, "R2 low read");
    step(0, '0, 1, LO, "R2 repeated low read");
    step(0, '0, 1, 8'h08, "R10 other offset");
    step(0, '0, 1, LO, "R2 low after other offset");
    // R9: push with pop on a partly filled queue
    step(0, '0, 1, HI, "R3 high pop");
    step(1, pat(7), 1, HI, "R9 push with pop");
    // R4: drain in order
    while (cnt > 0) begin
      step(0, '0, 1, LO, "R4 order low");
      step(0, '0, 1, HI, "R4 order high");
    end
    step(0, '0, 1, LO, "R8 empty after drain");
    // sweep: arithmetic mix of operations across many wraps
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      a = ((k % 5) == 0) ? LO : (((k % 7) == 3) ? 8'h0C : HI);
      step(((k * 3) % 5) < 3, pat(k + 100), ((k * 7) % 4) != 0, a,
           (a == LO) ? "R2 sweep" : ((a == HI) ? "R3 sweep" : "R10 sweep"));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule